// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block makes the SCL waveform for an I2C master from the system clock. A programmable prescaler divides the system clock into module-clock ticks: one tick every `psc_val + 1` system cycles. The low phase and the high phase of SCL are then timed in module ticks, each from its own count. Each phase lasts its programmed count plus a fixed pad term. The pad depends on the prescaler setting, or is pinned to 6 by a strap input. The SCL period in module ticks is therefore `(low_val + pad) + (high_val + pad)`.

The block is held in reset while `enable` is low. During that time it releases SCL and samples its configuration. When `enable` rises, a fresh period starts with the low phase. The output `scl_pull_low` is an open-drain request: 1 means "pull SCL low". The line level comes back on `scl_sense`. A slave that holds SCL low stretches the high phase, because the high phase does not count until the line is seen high. Two single-cycle strobes mark where each phase starts, for use by the bus engine. There is no data stream, so every pin is plain control.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, `scl_pull_low`, `fall_stb` and `rise_stb` are all 0.
- R2: `psc_val`, `low_val`, `high_val` and `pad_fixed` are captured only while `enable` is low. Changes while `enable` is high have no effect on the SCL timing.
- R3: The low phase (`scl_pull_low` = 1) lasts exactly `(low_val + pad) * (psc_val + 1)` system cycles.
- R4: With `scl_sense` high throughout, the high phase (`scl_pull_low` = 0 between two low phases) lasts exactly `(high_val + pad) * (psc_val + 1)` system cycles.
- R5: With `pad_fixed` = 0, pad is 7 when `psc_val` is 0, 6 when it is 1, and 5 when it is 2 or more.
- R6: With `pad_fixed` = 1, pad is 6 whatever `psc_val` is.
- R7: `high_val` = 0 is legal and gives a high phase of exactly `pad` module ticks.
- R8: During the high phase, every system cycle with `scl_sense` low freezes both the prescaler and the phase counter, so each such cycle lengthens the high phase by one cycle.
- R9: `fall_stb` is a one-cycle pulse in the first cycle of every low phase, and `rise_stb` is a one-cycle pulse in the first cycle of every high phase. A strobe is never high for two cycles in a row.
- R10: After `enable` is raised, the first cycle of activity is a low phase carrying `fall_stb`. When `enable` drops, SCL is released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run when 1; hold in reset and capture configuration when 0 |
| psc_val | input | 16 | Prescaler: one module tick every psc_val+1 cycles |
| low_val | input | 16 | Low-phase count in module ticks, before the pad |
| high_val | input | 16 | High-phase count in module ticks, before the pad |
| pad_fixed | input | 1 | 1 pins the pad term to 6 |
| scl_sense | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 requests SCL be driven low |
| fall_stb | output | 1 | One-cycle strobe at the start of each low phase |
| rise_stb | output | 1 | One-cycle strobe at the start of each high phase |

## Verification
The bench measures whole phases cycle by cycle for each of the three prescaler pad bands and for the strapped pad. A design with a wrong pad table would make one phase a few ticks short or long. A design that adds the pad only once per period would do the same. The zero high count is checked, because a design that decrements before comparing would wrap and produce a very long high phase. A slave stretch of known length is applied, because a design that let the prescaler run on during the stretch would come out short by a fraction of a tick. Configuration changes are made mid-run, because a design that reads its inputs live would retime at once. A disable and re-enable is also tested, because a design that resumes mid-phase would miss the opening fall strobe.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  // Pad term in module ticks, chosen by prescaler band or strap.
  function automatic logic [2:0] pad_ticks(input logic psc_zero, input logic psc_one,
                                           input logic strap);
    if (strap)         return 3'd6;
    else if (psc_zero) return 3'd7;
    else if (psc_one)  return 3'd6;
    else               return 3'd5;
  endfunction
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int CNT_W = 16,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] psc_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  input  logic             strap_in,
  output logic [CNT_W-1:0] psc_q,
  output logic [LIM_W-1:0] low_lim,
  output logic [LIM_W-1:0] high_lim
);
  import scl_div_pkg::*;

  logic [2:0] pad;
  assign pad = pad_ticks(psc_in == '0, psc_in == CNT_W'(1), strap_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q    <= '0;
      low_lim  <= LIM_W'(7);
      high_lim <= LIM_W'(7);
    end else if (!enable) begin
      psc_q    <= psc_in;
      low_lim  <= LIM_W'(low_in) + LIM_W'(pad);
      high_lim <= LIM_W'(high_in) + LIM_W'(pad);
    end
  end
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             advance,
  input  logic [CNT_W-1:0] psc_q,
  output logic             tick
);
  logic [CNT_W-1:0] div_cnt;

  assign tick = advance && (div_cnt == psc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!active)  div_cnt <= '0;
    else if (tick)     div_cnt <= '0;
    else if (advance)  div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int CNT_W = 16,
  localparam int LIM_W = CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     tick,
  input  logic [LIM_W-1:0]         low_lim,
  input  logic [LIM_W-1:0]         high_lim,
  output logic                     active,
  output scl_div_pkg::scl_phase_e  phase,
  output logic [LIM_W-1:0]         tick_cnt,
  output logic                     fall_stb,
  output logic                     rise_stb
);
  import scl_div_pkg::*;

  logic [LIM_W-1:0] cur_lim;
  assign cur_lim = (phase == PH_LOW) ? low_lim : high_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= PH_LOW; tick_cnt <= '0;
      fall_stb <= 1'b0; rise_stb <= 1'b0;
    end else if (!enable) begin
      active <= 1'b0; phase <= PH_LOW; tick_cnt <= '0;
      fall_stb <= 1'b0; rise_stb <= 1'b0;
    end else if (!active) begin
      active <= 1'b1; phase <= PH_LOW; tick_cnt <= '0;
      fall_stb <= 1'b1; rise_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (tick) begin
        if (tick_cnt == cur_lim - 1'b1) begin
          tick_cnt <= '0;
          if (phase == PH_LOW) begin
            phase <= PH_HIGH; rise_stb <= 1'b1;
          end else begin
            phase <= PH_LOW;  fall_stb <= 1'b1;
          end
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] psc_val,
  input  logic [CNT_W-1:0] low_val,
  input  logic [CNT_W-1:0] high_val,
  input  logic             pad_fixed,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             fall_stb,
  output logic             rise_stb
);
  import scl_div_pkg::*;
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] psc_q;
  logic [LIM_W-1:0] low_lim, high_lim, tick_cnt;
  logic             active, tick, advance, is_high;
  scl_phase_e       phase;

  scl_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .psc_in(psc_val), .low_in(low_val), .high_in(high_val), .strap_in(pad_fixed),
    .psc_q(psc_q), .low_lim(low_lim), .high_lim(high_lim)
  );

  // High phase only counts once the line is really high (slave stretch).
  assign is_high = (phase == PH_HIGH);
  assign advance = active && (!is_high || scl_sense);

  scl_prescale #(.CNT_W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .active(active), .advance(advance),
    .psc_q(psc_q), .tick(tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .low_lim(low_lim), .high_lim(high_lim),
    .active(active), .phase(phase), .tick_cnt(tick_cnt),
    .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  assign scl_pull_low = active && !is_high;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int CNT_W = 16,
  localparam int LIM_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             scl_sense,
  input logic             scl_pull_low,
  input logic             fall_stb,
  input logic             rise_stb,
  input logic [CNT_W-1:0] psc_q,
  input logic [LIM_W-1:0] hold_cnt,
  input logic             in_high
);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull_low && !fall_stb && !rise_stb));

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(psc_q));

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_sense && enable) |=> (in_high && $stable(hold_cnt)));

  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

  // R9
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_pull_low);

  // R10
  low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> fall_stb);
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_sense(scl_sense),
  .scl_pull_low(scl_pull_low), .fall_stb(fall_stb), .rise_stb(rise_stb),
  .psc_q(psc_q), .hold_cnt(tick_cnt), .in_high(is_high)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic clk = 0, rst_n = 0, enable = 0, pad_fixed = 0, slave_hold = 0;
  logic [15:0] psc_val = 0, low_val = 0, high_val = 0;
  logic scl_sense, scl_pull_low, fall_stb, rise_stb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign scl_sense = !scl_pull_low && !slave_hold;

  scl_rate_gen dut (.clk(clk), .rst_n(rst_n), .enable(enable), .psc_val(psc_val),
    .low_val(low_val), .high_val(high_val), .pad_fixed(pad_fixed),
    .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
    .fall_stb(fall_stb), .rise_stb(rise_stb));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pad_of(input int psc, input bit strap);
    if (strap) return 6;
    if (psc == 0) return 7;
    if (psc == 1) return 6;
    return 5;
  endfunction

  task automatic configure(input int p, input int l, input int h, input bit s);
    @(negedge clk);
    enable = 0; psc_val = 16'(p); low_val = 16'(l); high_val = 16'(h); pad_fixed = s;
    repeat (2) @(negedge clk);
    enable = 1;
  endtask

  // Measures one low phase and the following high phase; stretch = cycles held.
  task automatic measure(input int stretch, output int lo, output int hi);
    lo = 0; hi = 0;
    while (!fall_stb) @(negedge clk);
    chk("R9 fall strobe in low", int'(scl_pull_low), 1);
    while (scl_pull_low) begin
      lo++;
      @(negedge clk);
      if (scl_pull_low && lo == 1) chk("R9 fall one cycle", int'(fall_stb), 0);
    end
    chk("R9 rise strobe", int'(rise_stb), 1);
    while (!scl_pull_low) begin
      hi++;
      slave_hold = (hi <= stretch);
      @(negedge clk);
      if (hi == 1 && !scl_pull_low) chk("R9 rise one cycle", int'(rise_stb), 0);
    end
    slave_hold = 0;
  endtask

  task automatic t_timing(input string tag, input int p, input int l, input int h,
                          input bit s);
    int lo, hi, d;
    d = pad_of(p, s);
    configure(p, l, h, s);
    measure(0, lo, hi);
    chk({tag, " R3 low"}, lo, (l + d) * (p + 1));
    chk({tag, " R4 high"}, hi, (h + d) * (p + 1));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 pull after reset", int'(scl_pull_low), 0);
    chk("R1 strobes after reset", int'(fall_stb | rise_stb), 0);
  endtask

  task automatic t_stretch;
    int lo, hi;
    configure(1, 2, 3, 0);
    measure(5, lo, hi);
    chk("R8 stretched high", hi, (3 + 6) * 2 + 5);
    measure(0, lo, hi);
    chk("R8 unstretched high", hi, (3 + 6) * 2);
  endtask

  task automatic t_cfg_ignored;
    int lo, hi;
    configure(0, 2, 2, 0);
    measure(0, lo, hi);
    psc_val = 16'd4; low_val = 16'd9; high_val = 16'd9; pad_fixed = 1;
    measure(0, lo, hi);
    chk("R2 low unchanged", lo, 9);
    chk("R2 high unchanged", hi, 9);
  endtask

  task automatic t_disable;
    int lo, hi, seen;
    configure(2, 3, 3, 0);
    repeat (7) @(negedge clk);
    chk("R10 pulling before drop", int'(scl_pull_low), 1);
    enable = 0;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      seen += int'(scl_pull_low) + int'(fall_stb) + int'(rise_stb);
    end
    chk("R10 R1 released while off", seen, 0);
    enable = 1;
    @(negedge clk);
    chk("R10 restart with fall", int'(fall_stb), 1);
    measure(0, lo, hi);
    chk("R10 full period after restart", lo + hi, (3 + 5) * 3 * 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_timing("R5 psc0", 0, 3, 2, 0);
    t_timing("R5 R7 psc1 zero high", 1, 2, 0, 0);
    t_timing("R5 psc3", 3, 1, 4, 0);
    t_timing("R6 psc0 strap", 0, 3, 2, 1);
    t_timing("R6 psc2 strap", 2, 4, 1, 1);
    t_timing("R7 psc2 zero high", 2, 0, 0, 0);
    t_stretch();
    t_cfg_ignored();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule